// File: doc/BRIEF.md
# March Algorithm Memory Self-Test Controller

This block is a built-in self-test engine for a single-port, word-addressed SRAM with a one-cycle read latency. A test is started with a one-cycle pulse. From then on the block steps through a small built-in table of march elements, one memory operation per clock cycle. A march element is an ordered list of reads and writes of logical 0 or 1. It runs over every address in ascending or descending order. Every operation of the element finishes at an address before the address moves on. A pause element holds the memory idle for a fixed number of cycles so that data-retention faults can develop. Logical 0 is the data background word captured at start, and logical 1 is its bitwise inverse.

Each read is compared against its expected word in the cycle after the read strobe. The first mismatch records where it happened: the address, the element index and the operation index within the element. Later mismatches change nothing, and the algorithm still runs to its end. Two tables are built in. Table 0 is a six-element, ten-operation march of the C-minus kind. Table 1 is a retention variant with two pause elements and one six-operation element. Redundancy analysis and repair are not handled here.

Top module: `march_bist`

## Requirements
- R1: Within a march element, all of the element's operations are issued on consecutive cycles at one address. The address changes only after the element's last operation at that address.
- R2: An ascending element visits addresses 0 up to 2^ADDR_W-1. A descending element visits them in exactly the reverse order. A don't-care element is run ascending.
- R3: Elements run in table order. The next element starts in the cycle after the previous element's last operation at its final address, or the cycle after its last pause cycle.
- R4: A march element issues exactly one access per cycle, so a full run makes (operations per address) x 2^ADDR_W accesses. Both built-in tables total 10 operations per address. `done` stays low during the run and in the cycle after the last access, and goes high in the cycle after that.
- R5: A write of 0 drives the background word onto `mem_wdata`, and a write of 1 drives its bitwise inverse. Read and write strobes are never high together. The background is captured on the accepted start pulse, and later changes on `background` have no effect during the run.
- R6: A pause element lasts exactly PAUSE_CYCLES cycles with `mem_we` and `mem_re` both low.
- R7: Read data is compared in the cycle after `mem_re`. On the first mismatch, `fail` goes high in the cycle after that compare.
- R8: `fail`, `fail_addr`, `fail_elem` and `fail_op` record the first mismatch of a run and hold through later mismatches until the next accepted start, which clears `fail`. `fail_op` counts from 0 within the element.
- R9: After the run, `done` stays high and no access is issued. A start pulse seen while a run is in progress is ignored.
- R10: During and after reset, `done`, `fail`, `mem_we` and `mem_re` are low.
- R11: `algo_sel`=0 selects table 0: {any: w0; up: r0,w1; up: r1,w0; down: r0,w1; down: r1,w0; any: r0}. `algo_sel`=1 selects table 1: {any: w0; up: r0,w1,r1,w0,r0,w1; pause; down: r1,w0; pause; any: r0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted when idle or done |
| algo_sel | input | 1 | Table select, sampled with start |
| background | input | DATA_W | Data background for logical 0, sampled with start |
| mem_addr | output | ADDR_W | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after mem_re |
| done | output | 1 | Run complete |
| fail | output | 1 | At least one mismatch seen in this run |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 3 | Element index of the first mismatch |
| fail_op | output | 3 | Operation index of the first mismatch |

## Verification
The bench rebuilds the whole expected access stream for each run, one cycle at a time. A design that stepped the address inside an element, reversed the wrong elements, or ran a pause one cycle short or long shows up at the first cycle where it goes wrong. Two transition faults are placed so that a descending element reaches the higher address first. A design that recorded the last mismatch, or that overwrote the record, would report the wrong address and element. A stuck bit caught by the third operation of the six-operation element checks the operation index and the exact cycle in which `fail` rises. That rules out a compare made in the strobe cycle itself. One run changes `background` and pulses `start` in the middle. A design that tracked the live background or restarted would corrupt the write data or the stream.

// File: rtl/march_bist_pkg.sv
package march_bist_pkg;

  localparam int MAX_OPS   = 6;
  localparam int NUM_ELEMS = 6;
  localparam int ELEM_W    = 3;
  localparam int OPIDX_W   = 3;

  typedef enum logic [1:0] {DIR_UP = 2'd0, DIR_DOWN = 2'd1, DIR_ANY = 2'd2} dir_e;
  typedef enum logic {EK_MARCH = 1'b0, EK_PAUSE = 1'b1} kind_e;

  typedef struct packed {
    logic is_rd;
    logic val;
  } op_t;

  typedef struct packed {
    kind_e              kind;
    dir_e               dir;
    logic [OPIDX_W-1:0] nops;
    op_t [MAX_OPS-1:0]  ops;
  } elem_t;

  localparam op_t OP_W0 = '{is_rd: 1'b0, val: 1'b0};
  localparam op_t OP_W1 = '{is_rd: 1'b0, val: 1'b1};
  localparam op_t OP_R0 = '{is_rd: 1'b1, val: 1'b0};
  localparam op_t OP_R1 = '{is_rd: 1'b1, val: 1'b1};

  function automatic elem_t mk_march(input dir_e d, input logic [OPIDX_W-1:0] n,
                                     input op_t o0, input op_t o1, input op_t o2,
                                     input op_t o3, input op_t o4, input op_t o5);
    elem_t e;
    e.kind = EK_MARCH;
    e.dir  = d;
    e.nops = n;
    e.ops  = {o5, o4, o3, o2, o1, o0};
    return e;
  endfunction

  function automatic elem_t mk_pause();
    elem_t e;
    e.kind = EK_PAUSE;
    e.dir  = DIR_ANY;
    e.nops = '0;
    e.ops  = '0;
    return e;
  endfunction

  // Two built-in algorithms, six elements each, ten operations per address.
  function automatic elem_t table_entry(input logic sel, input logic [ELEM_W-1:0] idx);
    elem_t e;
    e = mk_pause();
    if (!sel) begin
      case (idx)
        3'd0: e = mk_march(DIR_ANY,  3'd1, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
        3'd1: e = mk_march(DIR_UP,   3'd2, OP_R0, OP_W1, OP_W0, OP_W0, OP_W0, OP_W0);
        3'd2: e = mk_march(DIR_UP,   3'd2, OP_R1, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
        3'd3: e = mk_march(DIR_DOWN, 3'd2, OP_R0, OP_W1, OP_W0, OP_W0, OP_W0, OP_W0);
        3'd4: e = mk_march(DIR_DOWN, 3'd2, OP_R1, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
        3'd5: e = mk_march(DIR_ANY,  3'd1, OP_R0, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
        default: e = mk_pause();
      endcase
    end else begin
      case (idx)
        3'd0: e = mk_march(DIR_ANY,  3'd1, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
        3'd1: e = mk_march(DIR_UP,   3'd6, OP_R0, OP_W1, OP_R1, OP_W0, OP_R0, OP_W1);
        3'd2: e = mk_pause();
        3'd3: e = mk_march(DIR_DOWN, 3'd2, OP_R1, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
        3'd4: e = mk_pause();
        3'd5: e = mk_march(DIR_ANY,  3'd1, OP_R0, OP_W0, OP_W0, OP_W0, OP_W0, OP_W0);
        default: e = mk_pause();
      endcase
    end
    return e;
  endfunction

  function automatic logic elem_is_pause(input logic sel, input logic [ELEM_W-1:0] idx);
    elem_t e;
    e = table_entry(sel, idx);
    return e.kind == EK_PAUSE;
  endfunction

  function automatic logic elem_is_down(input logic sel, input logic [ELEM_W-1:0] idx);
    elem_t e;
    e = table_entry(sel, idx);
    return e.dir == DIR_DOWN;
  endfunction

  function automatic logic [OPIDX_W-1:0] elem_nops(input logic sel, input logic [ELEM_W-1:0] idx);
    elem_t e;
    e = table_entry(sel, idx);
    return e.nops;
  endfunction

  function automatic op_t elem_op(input logic sel, input logic [ELEM_W-1:0] idx,
                                  input logic [OPIDX_W-1:0] k);
    elem_t e;
    op_t   o;
    e = table_entry(sel, idx);
    o = OP_W0;
    for (int i = 0; i < MAX_OPS; i++) begin
      if (k == OPIDX_W'(i)) o = e.ops[i];
    end
    return o;
  endfunction

endpackage

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_down,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic              down_q;
  logic [ADDR_W-1:0] addr_q;

  function automatic logic [ADDR_W-1:0] first_addr(input logic down);
    return down ? TOP_ADDR : '0;
  endfunction

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a, input logic down);
    return down ? a - 1'b1 : a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      addr_q <= first_addr(load_down);
      down_q <= load_down;
    end else if (step) begin
      addr_q <= next_addr(addr_q, down_q);
    end
  end

  assign addr = addr_q;
  assign last = down_q ? (addr_q == '0) : (addr_q == TOP_ADDR);

endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_bist_pkg::*;
#(
  parameter int PAUSE_CYCLES = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               algo_sel,
  input  logic               addr_last,
  output logic               run_start,
  output logic               issue,
  output logic               op_last,
  output logic               in_pause,
  output logic               done,
  output logic               addr_load,
  output logic               load_down,
  output logic               addr_step,
  output logic [ELEM_W-1:0]  elem_idx,
  output logic [OPIDX_W-1:0] op_idx,
  output op_t                cur_op
);
  localparam int PCNT_W = $clog2(PAUSE_CYCLES + 1);
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(PAUSE_CYCLES - 1);
  localparam logic [ELEM_W-1:0] ELEM_LAST = ELEM_W'(NUM_ELEMS - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_RUN, ST_PAUSE, ST_FINISH, ST_DONE} state_e;

  state_e             st_q, st_d;
  logic               sel_q, sel_d;
  logic [ELEM_W-1:0]  elem_q, elem_d, elem_nxt;
  logic [OPIDX_W-1:0] op_q, op_d;
  logic [PCNT_W-1:0]  pcnt_q, pcnt_d;
  logic               elem_final;

  assign elem_nxt   = elem_q + 1'b1;
  assign elem_final = (elem_q == ELEM_LAST);

  always_comb begin
    st_d      = st_q;
    sel_d     = sel_q;
    elem_d    = elem_q;
    op_d      = op_q;
    pcnt_d    = pcnt_q;
    addr_load = 1'b0;
    load_down = 1'b0;
    addr_step = 1'b0;
    issue     = (st_q == ST_RUN);
    op_last   = issue && (op_q == elem_nops(sel_q, elem_q) - 3'd1);
    run_start = start && ((st_q == ST_IDLE) || (st_q == ST_DONE));
    cur_op    = elem_op(sel_q, elem_q, op_q);
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (run_start) begin
          sel_d  = algo_sel;
          elem_d = '0;
          op_d   = '0;
          pcnt_d = '0;
          if (elem_is_pause(algo_sel, '0)) begin
            st_d = ST_PAUSE;
          end else begin
            st_d      = ST_RUN;
            addr_load = 1'b1;
            load_down = elem_is_down(algo_sel, '0);
          end
        end
      end
      ST_RUN: begin
        if (op_last) begin
          op_d = '0;
          if (addr_last) begin
            if (elem_final) begin
              st_d = ST_FINISH;
            end else begin
              elem_d = elem_nxt;
              pcnt_d = '0;
              if (elem_is_pause(sel_q, elem_nxt)) begin
                st_d = ST_PAUSE;
              end else begin
                addr_load = 1'b1;
                load_down = elem_is_down(sel_q, elem_nxt);
              end
            end
          end else begin
            addr_step = 1'b1;
          end
        end else begin
          op_d = op_q + 1'b1;
        end
      end
      ST_PAUSE: begin
        if (pcnt_q == PCNT_LAST) begin
          pcnt_d = '0;
          if (elem_final) begin
            st_d = ST_FINISH;
          end else begin
            elem_d = elem_nxt;
            if (!elem_is_pause(sel_q, elem_nxt)) begin
              st_d      = ST_RUN;
              addr_load = 1'b1;
              load_down = elem_is_down(sel_q, elem_nxt);
            end
          end
        end else begin
          pcnt_d = pcnt_q + 1'b1;
        end
      end
      ST_FINISH: st_d = ST_DONE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sel_q  <= 1'b0;
      elem_q <= '0;
      op_q   <= '0;
      pcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      elem_q <= elem_d;
      op_q   <= op_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign in_pause = (st_q == ST_PAUSE);
  assign done     = (st_q == ST_DONE);
  assign elem_idx = elem_q;
  assign op_idx   = op_q;

endmodule

// File: rtl/march_cmp.sv
module march_cmp
  import march_bist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               rd_issue,
  input  logic [DATA_W-1:0]  exp_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic [ELEM_W-1:0]  rd_elem,
  input  logic [OPIDX_W-1:0] rd_op,
  input  logic [DATA_W-1:0]  rdata,
  output logic               mismatch,
  output logic               fail,
  output logic [ADDR_W-1:0]  fail_addr,
  output logic [ELEM_W-1:0]  fail_elem,
  output logic [OPIDX_W-1:0] fail_op
);
  logic               pend_v;
  logic [DATA_W-1:0]  pend_exp;
  logic [ADDR_W-1:0]  pend_addr;
  logic [ELEM_W-1:0]  pend_elem;
  logic [OPIDX_W-1:0] pend_op;

  // Read data returns one cycle after the strobe; the tag travels with it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_exp  <= '0;
      pend_addr <= '0;
      pend_elem <= '0;
      pend_op   <= '0;
    end else begin
      pend_v <= rd_issue;
      if (rd_issue) begin
        pend_exp  <= exp_data;
        pend_addr <= rd_addr;
        pend_elem <= rd_elem;
        pend_op   <= rd_op;
      end
    end
  end

  assign mismatch = pend_v && (rdata != pend_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
      fail_op   <= '0;
    end else if (clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
      fail_op   <= '0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_addr <= pend_addr;
      fail_elem <= pend_elem;
      fail_op   <= pend_op;
    end
  end

endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_bist_pkg::*;
#(
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 8,
  parameter int PAUSE_CYCLES = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               algo_sel,
  input  logic [DATA_W-1:0]  background,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_we,
  output logic               mem_re,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               done,
  output logic               fail,
  output logic [ADDR_W-1:0]  fail_addr,
  output logic [ELEM_W-1:0]  fail_elem,
  output logic [OPIDX_W-1:0] fail_op
);
  logic               run_start, seq_issue, op_last, in_pause;
  logic               addr_load, load_down, addr_step, addr_last;
  logic               cmp_mismatch;
  logic [ELEM_W-1:0]  elem_idx;
  logic [OPIDX_W-1:0] op_idx;
  op_t                cur_op;
  logic [DATA_W-1:0]  bg_q, op_word;

  function automatic logic [DATA_W-1:0] bg_word(input logic [DATA_W-1:0] bg, input logic val);
    return val ? ~bg : bg;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bg_q <= '0;
    else if (run_start) bg_q <= background;
  end

  march_seq #(.PAUSE_CYCLES(PAUSE_CYCLES)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .algo_sel(algo_sel),
    .addr_last(addr_last), .run_start(run_start), .issue(seq_issue),
    .op_last(op_last), .in_pause(in_pause), .done(done),
    .addr_load(addr_load), .load_down(load_down), .addr_step(addr_step),
    .elem_idx(elem_idx), .op_idx(op_idx), .cur_op(cur_op)
  );

  march_addr_gen #(.ADDR_W(ADDR_W)) agen_i (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_down(load_down),
    .step(addr_step), .addr(mem_addr), .last(addr_last)
  );

  assign op_word   = bg_word(bg_q, cur_op.val);
  assign mem_we    = seq_issue && !cur_op.is_rd;
  assign mem_re    = seq_issue && cur_op.is_rd;
  assign mem_wdata = op_word;

  march_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cmp_i (
    .clk(clk), .rst_n(rst_n), .clear(run_start), .rd_issue(mem_re),
    .exp_data(op_word), .rd_addr(mem_addr), .rd_elem(elem_idx), .rd_op(op_idx),
    .rdata(mem_rdata), .mismatch(cmp_mismatch), .fail(fail),
    .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_op(fail_op)
  );

endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic              seq_issue,
  input logic              op_last,
  input logic              in_pause,
  input logic              run_start,
  input logic              cmp_mismatch
);
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_issue && !op_last) |=> (mem_addr == $past(mem_addr)));  // R1
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));  // R5
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_pause |-> !(mem_we || mem_re));  // R6
  AST_CMP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_mismatch |-> $past(mem_re));  // R7
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !run_start) |=> fail);  // R8
  AST_FAIL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !run_start) |=> $stable(fail_addr));  // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(mem_we || mem_re));  // R9
endmodule

bind march_bist march_bist_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
  .done(done), .fail(fail), .fail_addr(fail_addr), .seq_issue(seq_issue),
  .op_last(op_last), .in_pause(in_pause), .run_start(run_start),
  .cmp_mismatch(cmp_mismatch)
);

// File: tb/march_bist_tb_top.sv
`timescale 1ns/1ps
module march_bist_tb_top;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NW = 1 << AW;
  localparam int PC = 12;
  localparam logic [1:0] B_W0 = 2'b00, B_W1 = 2'b01, B_R0 = 2'b10, B_R1 = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          algo_sel = 1'b0;
  logic [DW-1:0] background = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          done, fail;
  logic [AW-1:0] fail_addr;
  logic [2:0]    fail_elem, fail_op;

  logic          mem_clr = 1'b1;
  logic [NW-1:0] stuck0_map = '0;
  logic [NW-1:0] tf_map = '0;
  logic [DW-1:0] mem [NW];

  int n_checks = 0, n_fail = 0;
  int cyc = 0, hit_cyc = -1, poke_cyc = -1;
  logic [DW-1:0] bg_run = '0;

  always #10 clk = ~clk;

  march_bist #(.ADDR_W(AW), .DATA_W(DW), .PAUSE_CYCLES(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .algo_sel(algo_sel),
    .background(background), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem),
    .fail_op(fail_op)
  );

  // Memory model: one-cycle read latency, optional stuck-at-0 and 1->0 transition faults on bit 0.
  always @(posedge clk) begin
    if (mem_clr) begin
      for (int i = 0; i < NW; i++) mem[i] <= '0;
    end else if (mem_we) begin
      if (stuck0_map[mem_addr])  mem[mem_addr] <= mem_wdata & 8'hFE;
      else if (tf_map[mem_addr]) mem[mem_addr] <= mem_wdata | (mem[mem_addr] & 8'h01);
      else                       mem[mem_addr] <= mem_wdata;
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic b_pause(input logic sel, input int e);
    return sel && (e == 2 || e == 4);
  endfunction
  function automatic logic b_down(input logic sel, input int e);
    return sel ? (e == 3) : (e == 3 || e == 4);
  endfunction
  function automatic int b_nops(input logic sel, input int e);
    if (e == 0 || e == 5) return 1;
    if (sel) return (e == 1) ? 6 : (e == 3) ? 2 : 0;
    return 2;
  endfunction
  function automatic logic [1:0] b_op(input logic sel, input int e, input int k);
    if (e == 0) return B_W0;
    if (e == 5) return B_R0;
    if (sel) begin
      if (e == 3) return (k == 0) ? B_R1 : B_W0;
      case (k)
        0: return B_R0;  1: return B_W1;  2: return B_R1;
        3: return B_W0;  4: return B_R0;  default: return B_W1;
      endcase
    end
    if (e == 1 || e == 3) return (k == 0) ? B_R0 : B_W1;
    return (k == 0) ? B_R1 : B_W0;
  endfunction

  task automatic step();
    if (hit_cyc >= 0 && cyc == hit_cyc + 1) check(fail === 1'b0, "R7 fail not yet set at compare", int'(fail), 0);
    if (hit_cyc >= 0 && cyc == hit_cyc + 2) check(fail === 1'b1, "R7 fail set after compare", int'(fail), 1);
    start = (cyc == poke_cyc);
    if (cyc == poke_cyc) background = ~bg_run;
    @(negedge clk);
    cyc++;
  endtask

  // Runs one algorithm and compares every cycle against the bench's own table.
  task automatic run_algo(input logic sel, input logic [DW-1:0] bg, input logic exp_f,
                          input int fa, input int fe, input int fo, input int poke);
    int nacc = 0;
    algo_sel = sel; background = bg; bg_run = bg; poke_cyc = poke; hit_cyc = -1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 0;
    check(fail === 1'b0, "R8 fail cleared by start", int'(fail), 0);
    for (int e = 0; e < 6; e++) begin
      if (b_pause(sel, e)) begin
        for (int c = 0; c < PC; c++) begin
          check(!mem_we && !mem_re, "R6 pause has no access", int'({mem_we, mem_re}), 0);
          check(done === 1'b0, "R4 done low in run", int'(done), 0);
          step();
        end
      end else begin
        for (int i = 0; i < NW; i++) begin
          int a;
          a = b_down(sel, e) ? NW - 1 - i : i;
          for (int k = 0; k < b_nops(sel, e); k++) begin
            logic [1:0] op;
            op = b_op(sel, e, k);
            check(int'(mem_addr) == a, "R1/R2 address order", int'(mem_addr), a);
            check(mem_re === op[1] && mem_we === !op[1], "R3 operation kind",
                  int'({mem_we, mem_re}), int'({!op[1], op[1]}));
            if (!op[1])
              check(mem_wdata === (op[0] ? ~bg : bg), "R5 write data", int'(mem_wdata),
                    int'(op[0] ? ~bg : bg));
            check(done === 1'b0, "R4 done low in run", int'(done), 0);
            if (exp_f && e == fe && a == fa && k == fo) hit_cyc = cyc;
            nacc++;
            step();
          end
        end
      end
    end
    check(nacc == 10 * NW, "R4 access count", nacc, 10 * NW);
    check(done === 1'b0, "R4 done low after last access", int'(done), 0);
    step();
    check(done === 1'b1, "R4 done high two cycles after last access", int'(done), 1);
    check(!mem_we && !mem_re, "R9 no access when done", int'({mem_we, mem_re}), 0);
    check(fail === exp_f, "R8 fail flag", int'(fail), int'(exp_f));
    if (exp_f) begin
      check(int'(fail_addr) == fa, "R8 fail_addr", int'(fail_addr), fa);
      check(int'(fail_elem) == fe, "R8 fail_elem", int'(fail_elem), fe);
      check(int'(fail_op) == fo, "R8 fail_op", int'(fail_op), fo);
    end
    @(negedge clk);
    check(done === 1'b1 && !mem_we && !mem_re, "R9 done holds, memory idle",
          int'({done, mem_we, mem_re}), 4);
    poke_cyc = -1;
  endtask

  task automatic reset_mem();
    mem_clr = 1'b1;
    @(negedge clk);
    mem_clr = 1'b0;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; mem_clr = 1'b1;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && fail === 1'b0, "R10 done/fail low in reset", int'({done, fail}), 0);
    check(!mem_we && !mem_re, "R10 no access in reset", int'({mem_we, mem_re}), 0);
    rst_n = 1'b1; mem_clr = 1'b0;
    @(negedge clk);
    check(done === 1'b0 && fail === 1'b0 && !mem_we && !mem_re, "R10 idle after reset",
          int'({done, fail, mem_we, mem_re}), 0);
  endtask

  task automatic t_table0_clean();  // R11 table 0, R2 directions
    stuck0_map = '0; tf_map = '0; reset_mem();
    run_algo(1'b0, 8'h00, 1'b0, 0, 0, 0, -1);
  endtask

  task automatic t_start_and_bg_ignored();  // R9, R5 background latched
    stuck0_map = '0; tf_map = '0; reset_mem();
    run_algo(1'b0, 8'hA5, 1'b0, 0, 0, 0, 50);
  endtask

  task automatic t_retention_table();  // R6, R11 table 1
    stuck0_map = '0; tf_map = '0; reset_mem();
    run_algo(1'b1, 8'h3C, 1'b0, 0, 0, 0, -1);
  endtask

  task automatic t_stuck_bit();  // R7, R8: third operation of the six-op element
    stuck0_map = 16'h0020; tf_map = '0; reset_mem();
    run_algo(1'b1, 8'h00, 1'b1, 5, 1, 2, -1);
  endtask

  task automatic t_two_transition_faults();  // R8 first recorded, R2 descending reaches 9 first
    stuck0_map = '0; tf_map = 16'h0220; reset_mem();
    run_algo(1'b0, 8'h00, 1'b1, 9, 3, 0, -1);
  endtask

  task automatic t_restart_clears();  // R8 cleared by next start
    stuck0_map = '0; tf_map = '0; reset_mem();
    run_algo(1'b0, 8'hFF, 1'b0, 0, 0, 0, -1);
  endtask

  initial begin
    t_reset_state();
    t_table0_clean();
    t_start_and_bg_ignored();
    t_retention_table();
    t_stuck_bit();
    t_two_transition_faults();
    t_restart_clears();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule